// File: doc/BRIEF.md
# Parity Error Status Controller

This block watches memory read data for byte parity errors on six memory banks: four banks reached through chip selects and two DRAM banks. On every read strobe it checks each enabled byte lane of the returned data against its parity bit, using either even or odd sense. A mismatch on a bank whose parity checking is enabled is logged in a sticky error flag kept for that bank.

A single 16-bit control and status word holds the flags, the parity sense, an interrupt enable and an 8-bit interrupt vector. It is written and read over a simple register bus. Software clears a flag by writing one to its bit.

While any flag is set, the block drives an error pin. If interrupts are enabled, it also raises an interrupt request at level 5 or 3, chosen by an external select input. During interrupt acknowledge it returns the programmed vector.

Top module: `parerr_status_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x0000, and `irq_req`, `par_err` and `iack_vec` are all low.
- R2: The register layout is fixed. Bit 15 is the interrupt enable and bit 14 is the odd-parity select. Bits 13..10 are chip-select bank flags 3..0, bits 9..8 are DRAM bank flags 1..0 and bits 7..0 are the vector. Bits 15, 14 and 7..0 are plain read/write, and a read always returns the current flag state.
- R3: With bit 14 = 0 a byte lane is in error when its 8 data bits plus its parity bit hold an odd number of ones. With bit 14 = 1 a lane is in error when that count is even. Lane n covers `rd_data[8n+7:8n]` and `rd_par[n]`.
- R4: A flag is set one clock after a cycle in which all of these hold: `rd_strobe` is high, the bank is selected, the bank's parity enable is high, and at least one lane with `lane_en` high is in error. Bank selection works as follows. With `bank_is_dram` = 0, `bank_idx` picks chip-select bank 0..3. With `bank_is_dram` = 1, `bank_idx[0]` picks DRAM bank 0 or 1.
- R5: No flag is set when `rd_strobe` is low, when the selected bank's parity enable is low, or when the only mismatching lanes have `lane_en` low.
- R6: A register write with a 1 in a flag bit clears that flag. A 0 in a flag bit leaves it unchanged.
- R7: When a flag is set by a read and cleared by a write in the same cycle, the flag ends up set.
- R8: `irq_req` is high exactly while bit 15 is 1 and any flag is set. `irq_level` is 5 when `lvl_sel` = 1 and 3 when `lvl_sel` = 0.
- R9: `par_err` is high exactly while any of the six flags is set, whatever the interrupt enable.
- R10: `iack_vec` equals bits 7..0 while `iack` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register contents |
| rd_strobe | input | 1 | Read data valid for parity check |
| rd_data | input | 32 | Read data bytes |
| rd_par | input | 4 | Parity bit per byte lane |
| lane_en | input | 4 | Byte lanes taking part in the access |
| bank_is_dram | input | 1 | 1 = DRAM bank, 0 = chip-select bank |
| bank_idx | input | 2 | Bank number within its class |
| cs_par_en | input | 4 | Parity enable per chip-select bank |
| dram_par_en | input | 2 | Parity enable per DRAM bank |
| lvl_sel | input | 1 | Interrupt level select (1 = level 5, 0 = level 3) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Interrupt level |
| par_err | output | 1 | Error pin, high while any flag is set |
| iack | input | 1 | Interrupt acknowledge |
| iack_vec | output | 8 | Vector returned on acknowledge |

## Verification
Several properties are checked on every cycle:
- a set flag stays set unless a write-one clear reaches it;
- a flag only rises right after a read strobe;
- a disabled lane never reports an error;
- the interrupt request never appears without the error pin;
- the vector output is zero outside acknowledge.

Only the directed scenarios can show the rest. These cover the even and odd parity sense on real data, the mapping of bank selection onto the six flag bits, the set-beats-clear race, and the two interrupt levels.

// File: rtl/parerr_pkg.sv
package parerr_pkg;
    localparam int LANE_W   = 8;
    localparam int CS_BANKS = 4;
    localparam int DR_BANKS = 2;
    localparam int N_FLAGS  = CS_BANKS + DR_BANKS;
    localparam int VEC_W    = 8;
    localparam int LVL_W    = 3;

    localparam logic [LVL_W-1:0] LEVEL_HI = 3'd5;
    localparam logic [LVL_W-1:0] LEVEL_LO = 3'd3;

    // Register image, most significant field first.
    typedef struct packed {
        logic                irq_en;
        logic                odd_sel;
        logic [CS_BANKS-1:0] cs_flag;
        logic [DR_BANKS-1:0] dr_flag;
        logic [VEC_W-1:0]    vec;
    } ctrl_reg_t;

    // Error test for one lane: count of ones in data plus parity bit.
    function automatic logic lane_bad(input logic [LANE_W-1:0] byte_v,
                                      input logic par_bit,
                                      input logic odd_sense);
        return (^byte_v) ^ par_bit ^ odd_sense;
    endfunction

    // One-hot hit on the flag vector: [N_FLAGS-1:DR_BANKS] chip selects, [DR_BANKS-1:0] DRAM.
    function automatic logic [N_FLAGS-1:0] bank_hit(input logic is_dram,
                                                    input logic [1:0] idx);
        logic [N_FLAGS-1:0] h;
        h = '0;
        if (is_dram) h[idx[0]] = 1'b1;
        else         h[DR_BANKS + int'(idx)] = 1'b1;
        return h;
    endfunction
endpackage

// File: rtl/parerr_lane_check.sv
module parerr_lane_check
    import parerr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES*LANE_W-1:0]  data,
    input  logic [LANES-1:0]         par,
    input  logic [LANES-1:0]         lane_en,
    input  logic                     odd_sense,
    output logic                     any_bad
);
    logic [LANES-1:0] bad;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bad[l] = lane_en[l] & lane_bad(data[l*LANE_W +: LANE_W], par[l], odd_sense);

        // R5
        lane_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !lane_en[l] |-> !bad[l]);
    end

    assign any_bad = |bad;
endmodule

// File: rtl/parerr_flag_bank.sv
module parerr_flag_bank
    import parerr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_FLAGS-1:0] set_vec,
    input  logic [N_FLAGS-1:0] clr_vec,
    output logic [N_FLAGS-1:0] flags
);
    logic [N_FLAGS-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    assign flags = flags_q;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_chk
        // R6
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (set_vec[i] && clr_vec[i]) |=> flags_q[i]);
    end
endmodule

// File: rtl/parerr_status_ctrl.sv
module parerr_status_ctrl
    import parerr_pkg::*;
#(
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    input  logic                 rd_strobe,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic [LANES-1:0]     rd_par,
    input  logic [LANES-1:0]     lane_en,
    input  logic                 bank_is_dram,
    input  logic [1:0]           bank_idx,
    input  logic [CS_BANKS-1:0]  cs_par_en,
    input  logic [DR_BANKS-1:0]  dram_par_en,
    input  logic                 lvl_sel,
    output logic                 irq_req,
    output logic [LVL_W-1:0]     irq_level,
    output logic                 par_err,
    input  logic                 iack,
    output logic [VEC_W-1:0]     iack_vec
);
    ctrl_reg_t          wr_img;
    ctrl_reg_t          rd_img;
    logic               irq_en_q;
    logic               odd_q;
    logic [VEC_W-1:0]   vec_q;
    logic               any_bad;
    logic [N_FLAGS-1:0] hit;
    logic [N_FLAGS-1:0] bank_en;
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] clr_vec;
    logic [N_FLAGS-1:0] flags;

    assign wr_img = ctrl_reg_t'(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q <= 1'b0;
            odd_q    <= 1'b0;
            vec_q    <= '0;
        end else if (reg_wr) begin
            irq_en_q <= wr_img.irq_en;
            odd_q    <= wr_img.odd_sel;
            vec_q    <= wr_img.vec;
        end
    end

    parerr_lane_check #(.LANES(LANES)) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .data      (rd_data),
        .par       (rd_par),
        .lane_en   (lane_en),
        .odd_sense (odd_q),
        .any_bad   (any_bad)
    );

    assign hit     = bank_hit(bank_is_dram, bank_idx);
    assign bank_en = {cs_par_en, dram_par_en};
    assign set_vec = (rd_strobe && any_bad) ? (hit & bank_en) : '0;
    assign clr_vec = reg_wr ? {wr_img.cs_flag, wr_img.dr_flag} : '0;

    parerr_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    always_comb begin
        rd_img         = '0;
        rd_img.irq_en  = irq_en_q;
        rd_img.odd_sel = odd_q;
        rd_img.cs_flag = flags[N_FLAGS-1:DR_BANKS];
        rd_img.dr_flag = flags[DR_BANKS-1:0];
        rd_img.vec     = vec_q;
    end

    assign reg_rdata = rd_img;
    assign par_err   = |flags;
    assign irq_req   = irq_en_q & par_err;
    assign irq_level = lvl_sel ? LEVEL_HI : LEVEL_LO;
    assign iack_vec  = iack ? vec_q : '0;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (reg_rdata == 16'h0000));
    // R4
    flag_rise_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~$past(flags))) |-> $past(rd_strobe));
    // R8
    irq_needs_err_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> par_err);
    // R10
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !iack |-> (iack_vec == '0));
endmodule

// File: tb/tb_parerr_status_ctrl.sv
module tb_parerr_status_ctrl;
    localparam int CLK_P = 10;
    localparam int LANES = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        rd_strobe;
    logic [31:0] rd_data;
    logic [3:0]  rd_par;
    logic [3:0]  lane_en;
    logic        bank_is_dram;
    logic [1:0]  bank_idx;
    logic [3:0]  cs_par_en;
    logic [1:0]  dram_par_en;
    logic        lvl_sel;
    logic        irq_req;
    logic [2:0]  irq_level;
    logic        par_err;
    logic        iack;
    logic [7:0]  iack_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    parerr_status_ctrl #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rd_par(rd_par), .lane_en(lane_en), .bank_is_dram(bank_is_dram),
        .bank_idx(bank_idx), .cs_par_en(cs_par_en), .dram_par_en(dram_par_en),
        .lvl_sel(lvl_sel), .irq_req(irq_req), .irq_level(irq_level),
        .par_err(par_err), .iack(iack), .iack_vec(iack_vec)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // Correct parity bits for data under the chosen sense.
    function automatic logic [3:0] good_par(input logic [31:0] d, input logic odd);
        logic [3:0] p;
        for (int l = 0; l < 4; l++) p[l] = (^d[l*8 +: 8]) ^ odd;
        return p;
    endfunction

    task automatic reg_write(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic mem_read(input logic dram, input logic [1:0] idx,
                            input logic [31:0] d, input logic [3:0] p);
        @(negedge clk);
        rd_strobe = 1'b1; bank_is_dram = dram; bank_idx = idx; rd_data = d; rd_par = p;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rdata", reg_rdata, 16'h0000);
        check("R1 irq", {15'd0, irq_req}, 16'd0);
        check("R1 par_err", {15'd0, par_err}, 16'd0);
        check("R1 iack_vec", {8'd0, iack_vec}, 16'd0);
    endtask

    task automatic t_rw;
        reg_write(16'hC0A5);
        check("R2 rw fields", reg_rdata, 16'hC0A5);
        reg_write(16'h0000);
        check("R2 rw cleared", reg_rdata, 16'h0000);
    endtask

    task automatic t_even;
        logic [31:0] d = 32'h12F0_7E81;
        mem_read(1'b0, 2'd2, d, good_par(d, 1'b0));
        check("R3 even good", reg_rdata, 16'h0000);
        mem_read(1'b0, 2'd2, d, good_par(d, 1'b0) ^ 4'b0010);
        check("R4 cs2 flag", reg_rdata, 16'h1000);
        check("R9 pin without ie", {15'd0, par_err}, 16'd1);
        check("R8 no irq without ie", {15'd0, irq_req}, 16'd0);
    endtask

    task automatic t_odd;
        logic [31:0] d = 32'hA5C3_0F11;
        reg_write(16'h7F00);
        check("R6 clear all, odd on", reg_rdata, 16'h4000);
        mem_read(1'b1, 2'd1, d, good_par(d, 1'b1));
        check("R3 odd good", reg_rdata, 16'h4000);
        mem_read(1'b1, 2'd1, d, good_par(d, 1'b0));
        check("R4 dram1 flag odd", reg_rdata, 16'h4200);
    endtask

    task automatic t_ignore;
        logic [31:0] d = 32'h0000_00FF;
        dram_par_en = 2'b10;
        mem_read(1'b1, 2'd0, d, ~good_par(d, 1'b1));
        check("R5 bank disabled", reg_rdata, 16'h4200);
        dram_par_en = 2'b11;
        lane_en = 4'b1110;
        mem_read(1'b0, 2'd0, d, good_par(d, 1'b1) ^ 4'b0001);
        check("R5 lane disabled", reg_rdata, 16'h4200);
        lane_en = 4'b1111;
        @(negedge clk);
        rd_strobe = 1'b0; bank_is_dram = 1'b0; bank_idx = 2'd3; rd_data = d;
        rd_par = ~good_par(d, 1'b1);
        @(negedge clk);
        check("R5 no strobe", reg_rdata, 16'h4200);
    endtask

    task automatic t_clear;
        reg_write(16'h4000);
        check("R6 write zero keeps", reg_rdata, 16'h4200);
        reg_write(16'h4200);
        check("R6 write one clears", reg_rdata, 16'h4000);
    endtask

    task automatic t_race;
        logic [31:0] d = 32'h3C3C_5A5A;
        @(negedge clk);
        rd_strobe = 1'b1; bank_is_dram = 1'b0; bank_idx = 2'd1; rd_data = d;
        rd_par = good_par(d, 1'b1) ^ 4'b1000;
        reg_wr = 1'b1; reg_wdata = 16'h4800;
        @(negedge clk);
        rd_strobe = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        check("R7 set beats clear", reg_rdata, 16'h4800);
        reg_write(16'h4800);
        check("R7 later clear", reg_rdata, 16'h4000);
    endtask

    task automatic t_irq;
        logic [31:0] d = 32'h0102_0408;
        mem_read(1'b0, 2'd0, d, ~good_par(d, 1'b1));
        check("R4 cs0 flag", reg_rdata, 16'h4400);
        check("R8 irq off", {15'd0, irq_req}, 16'd0);
        reg_write(16'hC000);
        check("R8 irq on", {15'd0, irq_req}, 16'd1);
        lvl_sel = 1'b1; #1;
        check("R8 level 5", {13'd0, irq_level}, 16'd5);
        lvl_sel = 1'b0; #1;
        check("R8 level 3", {13'd0, irq_level}, 16'd3);
        reg_write(16'hC400);
        check("R8 irq drops", {15'd0, irq_req}, 16'd0);
        check("R9 pin drops", {15'd0, par_err}, 16'd0);
    endtask

    task automatic t_iack;
        reg_write(16'h005A);
        @(negedge clk);
        iack = 1'b1; #1;
        check("R10 vector on ack", {8'd0, iack_vec}, 16'h005A);
        iack = 1'b0; #1;
        check("R10 zero off ack", {8'd0, iack_vec}, 16'h0000);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; reg_wr = 0; reg_wdata = '0; rd_strobe = 0; rd_data = '0;
        rd_par = '0; lane_en = 4'hF; bank_is_dram = 0; bank_idx = '0;
        cs_par_en = 4'hF; dram_par_en = 2'b11; lvl_sel = 0; iack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rw();
        t_even();
        t_odd();
        t_ignore();
        t_clear();
        t_race();
        t_irq();
        t_iack();
        finish_run();
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule